// File: doc/BRIEF.md
# Dual-Rail Threshold-Gate Handshake Register

This block is a multi-bit storage stage for a delay-insensitive pipeline built from dual-rail signals. Every bit is carried on a pair of rails: a "zero" rail and a "one" rail. Waves of complete data and waves of all-empty (Null) rails pass through the stage in alternation. The stage does not latch on a clock edge. Each output rail is held by a two-input threshold gate with hysteresis. That gate combines the matching input rail with the request line `ki`, which comes from the downstream stage. The gate switches on when both of its inputs are high. Once on, it stays on until both inputs have gone low.

A per-bit "holds data" flag feeds an N-input completion gate, which also has hysteresis. The inverted output of that gate is the acknowledge `ko`, sent back to the upstream stage. `ko` falls once every bit holds data, which asks the upstream stage for Null. `ko` rises again once every bit is Null, which asks for the next data set. In a chain of these registers, the `ko` of one stage drives the `ki` of the stage before it.

Each threshold gate is modelled as a state-holding element that re-evaluates on a fast gate-evaluation clock. The handshake on top of it does not depend on how many evaluation cycles a wave needs to arrive. An active-low reset is asserted asynchronously and released in step with the clock. Reset loads either all-Null or a chosen data word, selected by a parameter.

Top module: `ncl_hs_reg`

## Requirements
- R1: With the default parameters, while reset is applied and until the first wave arrives, every output rail is low (Null) and `ko` is high.
- R2: When `ki` is high and a bit's input carries data, the output rails take that data. Encoding: zero is `{one,zero}=01`, one is `10`, Null is `00`, and `11` is illegal.
- R3: While `ki` is low, data on the inputs does not reach the outputs: Null outputs stay Null and `ko` stays high.
- R4: An output rail that is high stays high until both its input rail and `ki` are low. Dropping only one of the two leaves the output data unchanged.
- R5: When the inputs are Null and `ki` is low, the outputs return to Null and `ko` returns high.
- R6: `ko` falls only after every bit holds data. While any bit is still Null, `ko` stays high.
- R7: `ko` rises only after every bit is Null. While any bit still holds data, `ko` stays low.
- R8: No output bit ever shows both rails high, provided the inputs never do.
- R9: With `RST_DATA=1`, reset loads `RST_VALUE` as data: one rails equal `RST_VALUE`, zero rails equal its complement, and `ko` is low. The word is held while `ki` stays high and is released to Null when `ki` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Gate-evaluation clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| din_r0 | input | N | Zero rail of each input bit |
| din_r1 | input | N | One rail of each input bit |
| ki | input | 1 | Request from the downstream stage (high asks for data, low asks for Null) |
| dout_r0 | output | N | Zero rail of each stored bit |
| dout_r1 | output | N | One rail of each stored bit |
| ko | output | 1 | Acknowledge to the upstream stage (low means data received, high means Null received) |

## Verification
Two functions can land in the same evaluation cycle: the downstream stage withdrawing its request (`ki` falling) and the upstream stage turning some bits to Null. Only the pairs whose two inputs are both low may release. The bench provokes this by dropping `ki` while part of the word is Null and part is still data, and by dropping `ki` and Null in close succession after random delays. It then checks that the Null bits clear while the data bits and a low `ko` are held. Per-rail clocked properties check every output rail transition against the rail and `ki` values one cycle earlier.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

  // Rail pair code: bit 1 is the one rail, bit 0 is the zero rail.
  typedef enum logic [1:0] {
    RAIL_NULL = 2'b00,
    RAIL_ZERO = 2'b01,
    RAIL_ONE  = 2'b10,
    RAIL_BAD  = 2'b11
  } rail_e;

  // Next value of a hysteresis threshold gate: it turns on when enough inputs
  // are high, and turns off only when no input is high.
  function automatic logic th_next(input logic q, input int unsigned hi_cnt,
                                   input int unsigned thresh);
    if (!q) th_next = (hi_cnt >= thresh);
    else    th_next = (hi_cnt != 0);
  endfunction

  // Reset code for one bit.
  function automatic rail_e rail_reset(input logic load_data, input logic val);
    if (!load_data) rail_reset = RAIL_NULL;
    else if (val)   rail_reset = RAIL_ONE;
    else            rail_reset = RAIL_ZERO;
  endfunction

endpackage

// File: rtl/ncl_rst_sync.sv
module ncl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/ncl_th_gate.sv
module ncl_th_gate
  import ncl_pkg::*;
#(
  parameter int   M     = 2,
  parameter int   N     = 2,
  parameter logic RST_Q = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] a,
  output logic         q
);
  localparam int unsigned THRESH = M;

  logic        q_d;
  int unsigned hi_cnt;

  always_comb begin
    hi_cnt = $countones(a);
    q_d    = th_next(q, hi_cnt, THRESH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_Q;
    else        q <= q_d;
  end
endmodule

// File: rtl/ncl_bit_slice.sv
module ncl_bit_slice
  import ncl_pkg::*;
#(
  parameter logic RST_DATA = 1'b0,
  parameter logic RST_BIT  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_r0,
  input  logic in_r1,
  input  logic ki,
  output logic out_r0,
  output logic out_r1,
  output logic has_data
);
  localparam rail_e RST_CODE = rail_reset(RST_DATA, RST_BIT);

  // Rail gates: each combines one input rail with the request line.
  ncl_th_gate #(.M(2), .N(2), .RST_Q(RST_CODE[0])) u_g0 (
    .clk (clk), .rst_n (rst_n), .a ({in_r0, ki}), .q (out_r0)
  );

  ncl_th_gate #(.M(2), .N(2), .RST_Q(RST_CODE[1])) u_g1 (
    .clk (clk), .rst_n (rst_n), .a ({in_r1, ki}), .q (out_r1)
  );

  // Data-present flag over the two stored rails.
  ncl_th_gate #(.M(1), .N(2), .RST_Q(RST_DATA)) u_flag (
    .clk (clk), .rst_n (rst_n), .a ({out_r1, out_r0}), .q (has_data)
  );
endmodule

// File: rtl/ncl_hs_reg.sv
module ncl_hs_reg #(
  parameter int         N         = 4,
  parameter logic       RST_DATA  = 1'b0,
  parameter logic [N-1:0] RST_VALUE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din_r0,
  input  logic [N-1:0] din_r1,
  input  logic         ki,
  output logic [N-1:0] dout_r0,
  output logic [N-1:0] dout_r1,
  output logic         ko
);
  logic         rst_q_n;
  logic [N-1:0] data_flag;
  logic         all_done;

  ncl_rst_sync #(.STAGES(2)) u_rst (
    .clk (clk), .rst_n (rst_n), .rst_q_n (rst_q_n)
  );

  for (genvar i = 0; i < N; i++) begin : g_bit
    ncl_bit_slice #(.RST_DATA(RST_DATA), .RST_BIT(RST_VALUE[i])) u_slice (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .in_r0    (din_r0[i]),
      .in_r1    (din_r1[i]),
      .ki       (ki),
      .out_r0   (dout_r0[i]),
      .out_r1   (dout_r1[i]),
      .has_data (data_flag[i])
    );
  end

  // Completion gate: all flags on to set, all flags off to clear.
  ncl_th_gate #(.M(N), .N(N), .RST_Q(RST_DATA)) u_done (
    .clk (clk), .rst_n (rst_q_n), .a (data_flag), .q (all_done)
  );

  assign ko = ~all_done;
endmodule

// File: rtl/ncl_hs_reg_chk.sv
module ncl_hs_reg_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] din_r0,
  input logic [N-1:0] din_r1,
  input logic         ki,
  input logic [N-1:0] dout_r0,
  input logic [N-1:0] dout_r1,
  input logic [N-1:0] data_flag,
  input logic         ko
);
  // R8: no bit shows both rails high, on either side.
  assert_out_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_r0 & dout_r1) == '0);
  assert_in_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (din_r0 & din_r1) == '0);

  // R6: acknowledge falls only after every bit flagged data.
  assert_ko_fall_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ko) |-> $past(&data_flag));
  // R7: acknowledge rises only after every bit flagged Null.
  assert_ko_rise_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ko) |-> $past(data_flag == '0));

  for (genvar i = 0; i < N; i++) begin : g_rail
    // R2 and R3: a rail rises only when its input rail and the request were both high.
    assert_rail0_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_r0[i]) |-> $past(din_r0[i] && ki));
    assert_rail1_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_r1[i]) |-> $past(din_r1[i] && ki));
    // R4: a rail falls only when its input rail and the request were both low.
    assert_rail0_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout_r0[i]) |-> $past(!din_r0[i] && !ki));
    assert_rail1_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dout_r1[i]) |-> $past(!din_r1[i] && !ki));
  end
endmodule

bind ncl_hs_reg ncl_hs_reg_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .din_r0    (din_r0),
  .din_r1    (din_r1),
  .ki        (ki),
  .dout_r0   (dout_r0),
  .dout_r1   (dout_r1),
  .data_flag (data_flag),
  .ko        (ko)
);

// File: tb/sim_ncl_hs_reg.sv
`timescale 1ns/1ps
module sim_ncl_hs_reg;
  localparam int N = 4;
  localparam logic [N-1:0] MASK = '1;
  localparam logic [N-1:0] RV   = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] din_r0 = '0, din_r1 = '0;
  logic ki = 1'b1;
  logic [N-1:0] dout_r0, dout_r1;
  logic ko;

  logic [N-1:0] b_r0, b_r1;
  logic b_ki = 1'b1;
  logic [N-1:0] b_out0, b_out1;
  logic b_ko;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ncl_hs_reg #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .din_r0(din_r0), .din_r1(din_r1), .ki(ki),
    .dout_r0(dout_r0), .dout_r1(dout_r1), .ko(ko)
  );

  assign b_r0 = '0;
  assign b_r1 = '0;
  ncl_hs_reg #(.N(N), .RST_DATA(1'b1), .RST_VALUE(RV)) u1 (
    .clk(clk), .rst_n(rst_n), .din_r0(b_r0), .din_r1(b_r1), .ki(b_ki),
    .dout_r0(b_out0), .dout_r1(b_out1), .ko(b_ko)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ko(input logic lvl, input string req);
    int k = 0;
    while (ko !== lvl && k < 50) begin @(negedge clk); k++; end
    check(req, {31'd0, ko}, {31'd0, lvl});
  endtask

  task automatic put_data(input logic [N-1:0] v);
    din_r1 = v;
    din_r0 = ~v & MASK;
  endtask

  task automatic t_reset();
    cycles(1);
    check("R1 dout_r0", {28'd0, dout_r0}, 0);
    check("R1 dout_r1", {28'd0, dout_r1}, 0);
    check("R1 ko", {31'd0, ko}, 1);
    check("R9 one rails", {28'd0, b_out1}, {28'd0, RV});
    check("R9 zero rails", {28'd0, b_out0}, {28'd0, ~RV});
    check("R9 ko", {31'd0, b_ko}, 0);
    rst_n = 1'b1;
    cycles(8);
    check("R9 held after release", {24'd0, b_out1, b_out0}, {24'd0, RV, ~RV});
    check("R1 still null", {24'd0, dout_r1, dout_r0}, 0);
    b_ki = 1'b0;
    cycles(8);
    check("R9 released null", {24'd0, b_out1, b_out0}, 0);
    check("R9 ko rises", {31'd0, b_ko}, 1);
  endtask

  task automatic t_blocked();
    ki = 1'b0;
    put_data(4'h5);
    cycles(8);
    check("R3 dout null", {24'd0, dout_r1, dout_r0}, 0);
    check("R3 ko high", {31'd0, ko}, 1);
    din_r0 = '0; din_r1 = '0;
    cycles(2);
    ki = 1'b1;
    cycles(2);
  endtask

  task automatic t_token(input logic [N-1:0] v);
    cycles($urandom_range(0, 5));
    put_data(v);
    wait_ko(1'b0, "R2 ko low");
    check("R2 data", {24'd0, dout_r1, dout_r0}, {24'd0, v, ~v & MASK});
    cycles($urandom_range(0, 5));
    din_r0 = '0; din_r1 = '0;
    cycles($urandom_range(0, 3));
    ki = 1'b0;
    wait_ko(1'b1, "R5 ko high");
    check("R5 null", {24'd0, dout_r1, dout_r0}, 0);
    cycles($urandom_range(0, 4));
    ki = 1'b1;
  endtask

  task automatic t_hyst();
    put_data(4'hC);
    wait_ko(1'b0, "R4 setup");
    ki = 1'b0;
    cycles(6);
    check("R4 held ki low", {24'd0, dout_r1, dout_r0}, {24'd0, 4'hC, 4'h3});
    ki = 1'b1;
    din_r0 = '0; din_r1 = '0;
    cycles(6);
    check("R4 held din null", {24'd0, dout_r1, dout_r0}, {24'd0, 4'hC, 4'h3});
    check("R4 ko low", {31'd0, ko}, 0);
    ki = 1'b0;
    wait_ko(1'b1, "R5 after hold");
    check("R5 cleared", {24'd0, dout_r1, dout_r0}, 0);
    ki = 1'b1;
    cycles(2);
  endtask

  task automatic t_partial();
    din_r1 = 4'b0011; din_r0 = 4'b0100;
    cycles(10);
    check("R6 ko stays high", {31'd0, ko}, 1);
    din_r0 = 4'b1100;
    wait_ko(1'b0, "R6 ko falls");
    // request withdrawn while half the word turns Null
    din_r1 = 4'b0000; din_r0 = 4'b1100;
    ki = 1'b0;
    cycles(10);
    check("R7 ko stays low", {31'd0, ko}, 0);
    check("R7 partial null", {24'd0, dout_r1, dout_r0}, {24'd0, 4'b0000, 4'b1100});
    din_r0 = '0;
    wait_ko(1'b1, "R7 ko rises");
    check("R7 all null", {24'd0, dout_r1, dout_r0}, 0);
    ki = 1'b1;
    cycles(2);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_blocked();
    t_token(4'h0);
    t_token(4'hF);
    t_token(4'h6);
    t_token(4'h9);
    for (int t = 0; t < 8; t++) t_token(4'($urandom_range(0, 15)));
    t_hyst();
    t_partial();
    finish_up();
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end
endmodule